// File: doc/BRIEF.md
# One-Step Transparent Clock Correction Updater

This block sits between the receive and transmit sides of a switch port pair and carries Ethernet frames as a byte stream. It recognises precision-time frames carried directly over Ethernet. For the two timed message kinds (Sync and Delay_Req) it adds the time the frame spent inside the block to the frame's 64-bit correction value. That value is counted in nanoseconds scaled by 2^16, and whatever earlier hops wrote is kept and accumulated onto. The rewrite happens as the frame leaves, so no follow-up message is ever produced.

Two timestamps are taken from the same free-running nanosecond counter, `time_now`. The first is taken in the cycle the first byte of a frame is accepted, and the second in the cycle the first byte of that frame is handed on. Frames are held in a byte queue until they have fully arrived, so their header fields are known before egress begins. A per-frame record (edit decision, drop decision, arrival time, original correction value) travels beside them in a small queue. Peer-delay request and response frames are removed from the stream. The updater can be disabled with `tc_en`, and a time base reported as invalid suppresses the edit, so such frames pass untouched.

Both stream sides use valid/ready. A byte moves on a rising edge where valid and ready are both high. `in_ready` does not depend on `in_valid`. While `out_valid` is high and `out_ready` low, the offered byte and its markers stay unchanged. The sender may hold `in_valid` low between bytes, and the receiver may hold `out_ready` low for any number of cycles.

Top module: `tc_cf_updater`

## Requirements
- R1: A byte moves only when valid and ready are both high. While `out_valid` is high and `out_ready` low, `out_valid`, `out_data`, `out_sop` and `out_eop` hold. `in_ready` is low when either the byte queue or the frame-record queue is full (record queue depth `META_DEPTH`, 4 by default).
- R2: A frame's first byte leaves only after its last byte was accepted, frames leave in arrival order, and a frame may be at most `DATA_DEPTH` bytes long.
- R3: A frame is a time frame when bytes 12 and 13 (counting from 0) are 0x88 and 0xF7; its message kind is the low nibble of byte 14 (the high nibble is ignored); kinds 0 (Sync) and 1 (Delay_Req) are the timed kinds.
- R4: The arrival time is `time_now` in the cycle of the input first-byte handshake; the departure time is `time_now` in the cycle of the output first-byte handshake.
- R5: For an edited frame, residence = (departure − arrival) mod 2^TIME_W, and bytes 22..29 (byte 22 most significant) leave as the big-endian value (old correction + residence·2^16) mod 2^64; all other bytes and the length are unchanged.
- R6: Frames with another EtherType, and time frames of kinds other than 0..3 (for example 8, 9, 11, 12, 13), leave byte for byte as they arrived.
- R7: If `tc_en` is low at the arrival handshake or at the departure handshake, the frame leaves unchanged.
- R8: If `time_ok` is low at either timestamp capture, the timestamp counts as lost and the frame leaves unchanged.
- R9: With `PDELAY_DROP` = 1 (default), time frames of kind 2 or 3 produce no output bytes; with 0 they pass unchanged.
- R10: A time frame shorter than 30 bytes leaves unchanged whatever its kind.
- R11: After reset, `out_valid` is low and `in_ready` is high.
- R12: Output framing is well formed: each frame begins with a byte marked `out_sop` and ends with one marked `out_eop`, and no output frame is produced that was not received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tc_en | input | 1 | Correction updating enabled for this port pair |
| time_ok | input | 1 | Time base valid; low marks a capture as lost |
| time_now | input | TIME_W | Shared free-running nanosecond counter |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte may be accepted |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | Input byte is the first of a frame |
| in_eop | input | 1 | Input byte is the last of a frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Receiver accepts the output byte |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | Output byte is the first of a frame |
| out_eop | output | 1 | Output byte is the last of a frame |

## Verification
The bench aims at the arithmetic edges of the correction. It uses an old correction near 2^64, where a design without a full-width carry or one that overwrites instead of accumulating gives the wrong sum. It also uses a time counter that wraps during residence, where a non-modular difference gives a huge residence. It covers the decision corners: a frame disabled only at departure, a lost arrival timestamp, a short time frame and a foreign EtherType. A design that keyed off the wrong capture or byte position would corrupt these frames. Peer-delay frames followed by a Sync, random output stalls and a full record queue expose designs that leak dropped frames, move data under back-pressure, or keep accepting bytes they cannot store.

// File: rtl/tccf_pkg.sv
package tccf_pkg;
  localparam int IDX_W = 5;
  typedef logic [IDX_W-1:0] idx_t;

  localparam idx_t IX_ET_HI = idx_t'(12);
  localparam idx_t IX_ET_LO = idx_t'(13);
  localparam idx_t IX_MT    = idx_t'(14);
  localparam idx_t IX_CF0   = idx_t'(22);
  localparam idx_t IX_CF7   = idx_t'(29);
  localparam idx_t IX_MAX   = '1;

  localparam logic [15:0] PTP_ETYPE = 16'h88F7;
  localparam int CF_W = 64;
  localparam int CF_FRAC = 16;

  typedef enum logic [3:0] {
    MK_SYNC   = 4'h0,
    MK_DREQ   = 4'h1,
    MK_PDREQ  = 4'h2,
    MK_PDRESP = 4'h3
  } msg_kind_e;

  function automatic logic kind_timed(input logic [3:0] k);
    return (k == MK_SYNC) || (k == MK_DREQ);
  endfunction

  function automatic logic kind_peer(input logic [3:0] k);
    return (k == MK_PDREQ) || (k == MK_PDRESP);
  endfunction
endpackage

// File: rtl/tccf_fifo.sv
module tccf_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0] cnt;

  assign full  = (cnt == (AW+1)'(DEPTH));
  assign empty = (cnt == '0);
  assign rdata = mem[rp];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
      case ({push && !full, pop && !empty})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/tccf_ing_parse.sv
module tccf_ing_parse
  import tccf_pkg::*;
#(
  parameter int TIME_W      = 32,
  parameter bit PDELAY_DROP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              sop,
  input  logic              eop,
  input  logic [7:0]        data,
  input  logic [TIME_W-1:0] time_now,
  input  logic              time_ok,
  input  logic              tc_en,
  output logic              rec_push,
  output logic              rec_edit,
  output logic              rec_drop,
  output logic [TIME_W-1:0] rec_ts,
  output logic [CF_W-1:0]   rec_cf
);
  idx_t cnt, idx;
  logic et_hi, et_ok, mk_seen, hdr_full, cap_ok;
  logic [3:0] mk;
  logic [CF_W-1:0] cf;
  logic [TIME_W-1:0] ts;

  logic n_et_hi, n_et_ok, n_mk_seen, n_hdr_full, n_cap_ok;
  logic [3:0] n_mk;
  logic [CF_W-1:0] n_cf;
  logic [TIME_W-1:0] n_ts;
  logic drop_sel;

  assign idx = sop ? '0 : cnt;

  always_comb begin
    n_et_hi    = et_hi;
    n_et_ok    = et_ok;
    n_mk_seen  = mk_seen;
    n_mk       = mk;
    n_cf       = cf;
    n_hdr_full = hdr_full;
    n_ts       = ts;
    n_cap_ok   = cap_ok;
    if (fire) begin
      if (sop) begin
        n_et_hi    = 1'b0;
        n_et_ok    = 1'b0;
        n_mk_seen  = 1'b0;
        n_mk       = '0;
        n_hdr_full = 1'b0;
        n_ts       = time_now;
        n_cap_ok   = tc_en && time_ok;
      end
      if (idx == IX_ET_HI) n_et_hi = (data == PTP_ETYPE[15:8]);
      if (idx == IX_ET_LO) n_et_ok = n_et_hi && (data == PTP_ETYPE[7:0]);
      if (idx == IX_MT) begin
        n_mk_seen = 1'b1;
        n_mk      = data[3:0];
      end
      if (idx >= IX_CF0 && idx <= IX_CF7) n_cf = {cf[CF_W-9:0], data};
      if (idx == IX_CF7) n_hdr_full = 1'b1;
    end
  end

  generate
    if (PDELAY_DROP) begin : g_drop
      assign drop_sel = n_et_ok && n_mk_seen && kind_peer(n_mk);
    end else begin : g_pass
      assign drop_sel = 1'b0;
    end
  endgenerate

  assign rec_push = fire && eop;
  assign rec_edit = n_et_ok && n_hdr_full && kind_timed(n_mk) && n_cap_ok;
  assign rec_drop = drop_sel;
  assign rec_ts   = n_ts;
  assign rec_cf   = n_cf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      et_hi    <= 1'b0;
      et_ok    <= 1'b0;
      mk_seen  <= 1'b0;
      mk       <= '0;
      cf       <= '0;
      hdr_full <= 1'b0;
      ts       <= '0;
      cap_ok   <= 1'b0;
    end else begin
      if (fire) cnt <= (idx == IX_MAX) ? idx : idx + idx_t'(1);
      et_hi    <= n_et_hi;
      et_ok    <= n_et_ok;
      mk_seen  <= n_mk_seen;
      mk       <= n_mk;
      cf       <= n_cf;
      hdr_full <= n_hdr_full;
      ts       <= n_ts;
      cap_ok   <= n_cap_ok;
    end
  end
endmodule

// File: rtl/tccf_egr_edit.sv
module tccf_egr_edit
  import tccf_pkg::*;
#(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d_valid,
  input  logic [7:0]        d_data,
  input  logic              d_sop,
  input  logic              d_eop,
  input  logic              r_valid,
  input  logic              r_edit,
  input  logic              r_drop,
  input  logic [TIME_W-1:0] r_ts,
  input  logic [CF_W-1:0]   r_cf,
  input  logic [TIME_W-1:0] time_now,
  input  logic              time_ok,
  input  logic              tc_en,
  input  logic              out_ready,
  output logic              d_pop,
  output logic              r_pop,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_sop,
  output logic              out_eop
);
  idx_t cnt, idx;
  logic avail, xfer, act, in_cf;
  logic [CF_W-1:0] sum;
  logic [TIME_W-1:0] resid;
  logic [2:0] bsel;

  assign avail     = d_valid && r_valid;
  assign out_valid = avail && !r_drop;
  assign xfer      = out_valid && out_ready;
  assign d_pop     = xfer || (avail && r_drop);
  assign r_pop     = d_pop && d_eop;
  assign idx       = d_sop ? '0 : cnt;
  assign resid     = time_now - r_ts;

  assign in_cf    = act && !d_sop && (idx >= IX_CF0) && (idx <= IX_CF7);
  assign bsel     = 3'(IX_CF7 - idx);
  assign out_data = in_cf ? 8'(sum >> {bsel, 3'b000}) : d_data;
  assign out_sop  = d_sop;
  assign out_eop  = d_eop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      act <= 1'b0;
      sum <= '0;
    end else begin
      if (d_pop) cnt <= (idx == IX_MAX) ? idx : idx + idx_t'(1);
      if (xfer && d_sop) begin
        act <= r_edit && tc_en && time_ok;
        sum <= r_cf + (CF_W'(resid) << CF_FRAC);
      end
    end
  end
endmodule

// File: rtl/tc_cf_updater.sv
module tc_cf_updater
  import tccf_pkg::*;
#(
  parameter int TIME_W      = 32,
  parameter int DATA_DEPTH  = 128,
  parameter int META_DEPTH  = 4,
  parameter bit PDELAY_DROP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tc_en,
  input  logic              time_ok,
  input  logic [TIME_W-1:0] time_now,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_sop,
  output logic              out_eop
);
  localparam int DW = 10;
  localparam int MW = 2 + TIME_W + CF_W;

  logic in_fire;
  logic d_full, d_empty, d_pop;
  logic [DW-1:0] d_rdata;
  logic m_full, m_empty, m_push, m_pop;
  logic [MW-1:0] m_wdata, m_rdata;
  logic w_edit, w_drop;
  logic [TIME_W-1:0] w_ts;
  logic [CF_W-1:0] w_cf;

  assign in_ready = !d_full && !m_full;
  assign in_fire  = in_valid && in_ready;

  tccf_fifo #(.W(DW), .DEPTH(DATA_DEPTH)) u_bytes (
    .clk(clk), .rst_n(rst_n),
    .push(in_fire), .wdata({in_sop, in_eop, in_data}),
    .pop(d_pop), .rdata(d_rdata), .full(d_full), .empty(d_empty)
  );

  tccf_ing_parse #(.TIME_W(TIME_W), .PDELAY_DROP(PDELAY_DROP)) u_parse (
    .clk(clk), .rst_n(rst_n), .fire(in_fire), .sop(in_sop), .eop(in_eop),
    .data(in_data), .time_now(time_now), .time_ok(time_ok), .tc_en(tc_en),
    .rec_push(m_push), .rec_edit(w_edit), .rec_drop(w_drop),
    .rec_ts(w_ts), .rec_cf(w_cf)
  );

  assign m_wdata = {w_edit, w_drop, w_ts, w_cf};

  tccf_fifo #(.W(MW), .DEPTH(META_DEPTH)) u_recs (
    .clk(clk), .rst_n(rst_n),
    .push(m_push), .wdata(m_wdata),
    .pop(m_pop), .rdata(m_rdata), .full(m_full), .empty(m_empty)
  );

  tccf_egr_edit #(.TIME_W(TIME_W)) u_edit (
    .clk(clk), .rst_n(rst_n),
    .d_valid(!d_empty), .d_data(d_rdata[7:0]),
    .d_sop(d_rdata[9]), .d_eop(d_rdata[8]),
    .r_valid(!m_empty), .r_edit(m_rdata[MW-1]), .r_drop(m_rdata[MW-2]),
    .r_ts(m_rdata[CF_W +: TIME_W]), .r_cf(m_rdata[CF_W-1:0]),
    .time_now(time_now), .time_ok(time_ok), .tc_en(tc_en),
    .out_ready(out_ready), .d_pop(d_pop), .r_pop(m_pop),
    .out_valid(out_valid), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop)
  );
endmodule

// File: rtl/tc_cf_updater_chk.sv
module tc_cf_updater_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_eop,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sop,
  input logic       out_eop
);
  logic o_inframe;
  logic [15:0] in_done, out_started;
  logic ofire;

  assign ofire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_inframe   <= 1'b0;
      in_done     <= '0;
      out_started <= '0;
    end else begin
      if (in_valid && in_ready && in_eop) in_done <= in_done + 16'd1;
      if (ofire && out_sop) out_started <= out_started + 16'd1;
      if (ofire) o_inframe <= !out_eop;
    end
  end

  // R1: an offered byte is held under back-pressure
  a_r1_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop));

  // R12: a first byte never lands inside an open frame
  a_r12_sop_outside: assert property (@(posedge clk) disable iff (!rst_n)
    ofire && out_sop |-> !o_inframe);

  // R12: a non-first byte only inside an open frame
  a_r12_body_inside: assert property (@(posedge clk) disable iff (!rst_n)
    ofire && !out_sop |-> o_inframe);

  // R2: egress of a frame starts only after more frames completed ingress than started egress
  a_r2_store_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    ofire && out_sop |-> in_done > out_started);
endmodule

bind tc_cf_updater tc_cf_updater_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_eop(in_eop), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop)
);

// File: tb/tb_tc_cf_updater.sv
module tb_tc_cf_updater;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tc_en = 1'b1;
  logic time_ok = 1'b1;
  logic [31:0] tnow = 32'd1000;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_valid, out_sop, out_eop;
  logic [7:0] out_data;
  logic out_ready = 1'b0;

  logic hold_rdy = 1'b1, bp_mode = 1'b0, tl_req = 1'b0;
  logic [31:0] tl_val = 32'd0;
  logic [7:0] lfsr = 8'h5A;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] tx [0:127];
  int tx_len;
  logic [63:0] cur_cf;
  logic [31:0] ing_t, ing_eop_t;

  logic [7:0] rx [0:127];
  int rx_len = 0, rx_pos = 0, rx_cnt = 0, frm_err = 0;
  bit rx_in = 0;
  logic [31:0] rx_egr_t;

  tc_cf_updater dut (
    .clk(clk), .rst_n(rst_n), .tc_en(tc_en), .time_ok(time_ok), .time_now(tnow),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tnow      <= tl_req ? tl_val : tnow + 32'd1;
    lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= bp_mode ? lfsr[2] : hold_rdy;
  end

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (out_sop) begin
        if (rx_in) frm_err++;
        rx_in = 1;
        rx_pos = 0;
        rx_egr_t = tnow;
      end else if (!rx_in) frm_err++;
      rx[rx_pos] = out_data;
      rx_pos++;
      if (out_eop) begin
        rx_in = 0;
        rx_len = rx_pos;
        rx_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  task automatic build(input logic [15:0] et, input logic [7:0] b14,
                       input logic [63:0] cf, input int len);
    for (int i = 0; i < len; i++) tx[i] = 8'(i * 7 + 3);
    tx[12] = et[15:8];
    tx[13] = et[7:0];
    if (len > 14) tx[14] = b14;
    if (len >= 30) for (int i = 0; i < 8; i++) tx[22+i] = cf[63-8*i -: 8];
    tx_len = len;
    cur_cf = cf;
  endtask

  task automatic send;
    for (int i = 0; i < tx_len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = tx[i];
      in_sop   = (i == 0);
      in_eop   = (i == tx_len - 1);
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
      if (i == 0) ing_t = tnow;
      if (i == tx_len - 1) ing_eop_t = tnow;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sop   = 1'b0;
    in_eop   = 1'b0;
  endtask

  task automatic wait_rx(input int target, input string req);
    int n = 0;
    while (rx_cnt < target && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(rx_cnt >= target, req, "frame arrival", 64'(rx_cnt), 64'(target));
  endtask

  task automatic check_frame(input string req, input bit edited);
    logic [7:0] exp [0:127];
    logic [31:0] rt;
    logic [63:0] ecf, gcf;
    int bad = -1;
    for (int i = 0; i < tx_len; i++) exp[i] = tx[i];
    rt = rx_egr_t - ing_t;
    ecf = cur_cf + (64'(rt) << 16);
    if (edited) for (int i = 0; i < 8; i++) exp[22+i] = ecf[63-8*i -: 8];
    chk(rx_len == tx_len, req, "length", 64'(rx_len), 64'(tx_len));
    for (int i = 0; i < tx_len; i++) if (bad < 0 && rx[i] !== exp[i]) bad = i;
    chk(bad < 0, req, "bytes", (bad < 0) ? 64'd0 : 64'(rx[bad]),
        (bad < 0) ? 64'd0 : 64'(exp[bad]));
    if (edited) begin
      gcf = '0;
      for (int i = 0; i < 8; i++) gcf = {gcf[55:0], rx[22+i]};
      chk(gcf == ecf, req, "correction", gcf, ecf);
      chk((rx_egr_t - ing_eop_t) > 0 && (rx_egr_t - ing_eop_t) < 32'd1000, "R2",
          "egress start after ingress end", 64'(rx_egr_t - ing_eop_t), 64'd1);
    end
  endtask

  task automatic run_one(input string req, input logic [15:0] et, input logic [7:0] b14,
                         input logic [63:0] cf, input int len, input bit edited);
    int base = rx_cnt;
    build(et, b14, cf, len);
    send();
    wait_rx(base + 1, req);
    check_frame(req, edited);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11", "out_valid after reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R11", "in_ready after reset", 64'(in_ready), 64'd1);
  endtask

  task automatic t_sync;
    run_one("R5", 16'h88F7, 8'h10, 64'd0, 64, 1'b1);
    run_one("R3", 16'h88F7, 8'hA0, 64'h0000_0000_0123_0000, 40, 1'b1);
  endtask

  task automatic t_accum;
    run_one("R5", 16'h88F7, 8'h11, 64'hFFFF_FFFF_FFFF_0000, 48, 1'b1);
    run_one("R4", 16'h88F7, 8'h01, 64'h0000_1234_0000_FFFF, 30, 1'b1);
  endtask

  task automatic t_general;
    logic [7:0] kinds [5] = '{8'h18, 8'h19, 8'h1B, 8'h1C, 8'h1D};
    for (int k = 0; k < 5; k++)
      run_one("R6", 16'h88F7, kinds[k], 64'h0000_0000_00AB_0000, 44, 1'b0);
  endtask

  task automatic t_foreign;
    run_one("R6", 16'h0800, 8'h00, 64'h1111_2222_3333_4444, 60, 1'b0);
  endtask

  task automatic t_disabled;
    int base;
    tc_en = 1'b0;
    run_one("R7", 16'h88F7, 8'h10, 64'h77, 40, 1'b0);
    tc_en = 1'b1;
    hold_rdy = 1'b0;
    base = rx_cnt;
    build(16'h88F7, 8'h10, 64'h55, 40);
    send();
    repeat (3) @(negedge clk);
    tc_en = 1'b0;
    hold_rdy = 1'b1;
    wait_rx(base + 1, "R7");
    check_frame("R7", 1'b0);
    tc_en = 1'b1;
  endtask

  task automatic t_lost_ts;
    time_ok = 1'b0;
    build(16'h88F7, 8'h10, 64'h99, 40);
    fork
      send();
      begin
        repeat (3) @(negedge clk);
        time_ok = 1'b1;
      end
    join
    wait_rx(rx_cnt + ((rx_cnt >= 0) ? 0 : 0) + 1 - ((rx_cnt >= 1 && 0) ? 1 : 0), "R8");
    check_frame("R8", 1'b0);
  endtask

  task automatic t_pdelay;
    int base = rx_cnt;
    build(16'h88F7, 8'h12, 64'h0, 50);
    send();
    build(16'h88F7, 8'h13, 64'h0, 50);
    send();
    build(16'h88F7, 8'h10, 64'h0000_0000_0042_0000, 50);
    send();
    wait_rx(base + 1, "R9");
    check_frame("R9", 1'b1);
    repeat (60) @(negedge clk);
    chk(rx_cnt == base + 1, "R9", "peer-delay frames dropped", 64'(rx_cnt - base), 64'd1);
  endtask

  task automatic t_short;
    run_one("R10", 16'h88F7, 8'h10, 64'h0, 24, 1'b0);
    run_one("R10", 16'h88F7, 8'h11, 64'h0, 29, 1'b0);
  endtask

  task automatic t_wrap;
    @(negedge clk);
    tl_val = 32'hFFFF_FFF0;
    tl_req = 1'b1;
    @(negedge clk);
    tl_req = 1'b0;
    run_one("R5", 16'h88F7, 8'h10, 64'h0000_0000_0007_0000, 64, 1'b1);
  endtask

  task automatic t_backpressure;
    bp_mode = 1'b1;
    run_one("R1", 16'h88F7, 8'h10, 64'h0000_0001_0000_0000, 64, 1'b1);
    run_one("R1", 16'h88F7, 8'h01, 64'h0, 33, 1'b1);
    bp_mode = 1'b0;
  endtask

  task automatic t_fill;
    int base = rx_cnt;
    hold_rdy = 1'b0;
    repeat (2) @(negedge clk);
    for (int f = 0; f < 4; f++) begin
      build(16'h0800, 8'h00, 64'h0, 16);
      send();
    end
    repeat (2) @(negedge clk);
    chk(in_ready == 1'b0, "R1", "in_ready low with record queue full", 64'(in_ready), 64'd0);
    chk(rx_cnt == base, "R1", "nothing leaves while stalled", 64'(rx_cnt - base), 64'd0);
    hold_rdy = 1'b1;
    wait_rx(base + 4, "R1");
    check_frame("R1", 1'b0);
    chk(in_ready == 1'b1, "R1", "in_ready back high", 64'(in_ready), 64'd1);
  endtask

  task automatic t_framing;
    chk(frm_err == 0, "R12", "output framing errors", 64'(frm_err), 64'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_sync();
    t_accum();
    t_general();
    t_foreign();
    t_disabled();
    t_lost_ts();
    t_pdelay();
    t_short();
    t_wrap();
    t_backpressure();
    t_fill();
    t_framing();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired got=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule